// File: doc/BRIEF.md
# Phase-Shift Edge Scheduler with Transient Offset Correction

This block runs once per switching period of a two-bridge isolated DC/DC converter. It takes a signed, normalized phase-shift request and turns it into four compare values for an up-down carrier timer. The carrier counts up to a peak and back down, so one switching period is twice the peak count. The four values are a rising and a falling edge instant for each bridge. With no correction, the falling edges sit symmetrically about mid-period. The rising edges get an extra term equal to a quarter of the change in phase shift since the previous period. This term delays one bridge's rising edge and advances the other's by the same amount. It uses no measurements and no branches, and it stops a DC offset from building up in the transformer current when the request steps.

The request is a Q1.15 fraction of a period, saturated to ±0.25 (±90 degrees). Negative values mean reverse power flow. A pulse on `cycle_start`, given at the start of each period, samples the request. It also stores the saturated value as the previous phase shift and loads all four compare registers at once. Between pulses the outputs hold.

Top module: `phase_edge_calc`

## Requirements
- R1: The request is saturated to the range −8192..+8192 in Q1.15 (±0.25 of a period) before any use. The saturated value is the one used for both the edge offsets and the stored previous value.
- R2: With PEAK = 1250, MID = 625 and h = floor(s·1250/32768 + 0.5), where s is the saturated request, the primary falling compare is MID + h and the secondary falling compare is MID − h. These are down-count compare values, and the falling compares never include the correction.
- R3: With delta = s − s_prev and c = floor(delta·625/32768 + 0.5), the primary rising compare is MID − h + c and the secondary rising compare is MID + h − c. These are up-count compare values.
- R4: s_prev is the saturated request applied at the most recent `cycle_start`, and it changes only on a `cycle_start`.
- R5: Every compare value is clamped to the range MARGIN..PEAK−MARGIN. The default MARGIN is 1, giving 1..1249.
- R6: The outputs take their new values on the clock edge that samples `cycle_start` high, and they hold on every other edge whatever `ds_req` does.
- R7: While `rst_n` is low, all four compares are MID (625) and s_prev is zero.
- R8: After reset, the first period's correction is a quarter of the first (saturated) request, because s_prev starts at zero.
- R9: The two rising compares always add up to PEAK, and so do the two falling compares.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cycle_start | input | 1 | One-clock pulse at the start of each switching period |
| ds_req | input | 16 | Signed Q1.15 phase-shift request |
| pri_rise_cmp | output | 11 | Primary bridge rising edge, up-count compare |
| sec_rise_cmp | output | 11 | Secondary bridge rising edge, up-count compare |
| pri_fall_cmp | output | 11 | Primary bridge falling edge, down-count compare |
| sec_fall_cmp | output | 11 | Secondary bridge falling edge, down-count compare |

## Verification
On every cycle, the assertions check that each compare stays inside the clamp window. They also check that each rising pair and each falling pair sums to the peak, and that the outputs hold when no period start arrives. Only the bench scenarios can show the actual tick values, the rounding of the half offset and of the quarter correction, and saturation of out-of-range requests. The same holds for the stored previous value carrying the saturated request into the next delta, and for the first-period correction after reset. A second instance with a wide margin makes the clamp act, since the default window is never reached.

// File: rtl/phase_edge_calc.sv
module phase_edge_calc #(
  parameter int W      = 16,
  parameter int FRAC   = 15,
  parameter int PEAK   = 1250,
  parameter int MARGIN = 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cycle_start,
  input  logic signed [W-1:0]           ds_req,
  output logic [$clog2(PEAK+1)-1:0]     pri_rise_cmp,
  output logic [$clog2(PEAK+1)-1:0]     sec_rise_cmp,
  output logic [$clog2(PEAK+1)-1:0]     pri_fall_cmp,
  output logic [$clog2(PEAK+1)-1:0]     sec_fall_cmp
);
  localparam int CW  = $clog2(PEAK+1);
  localparam int XW  = W + CW + 4;
  localparam int MID = PEAK / 2;

  localparam logic signed [XW-1:0] LIM    = XW'(longint'(1) << (FRAC-2));
  localparam logic signed [XW-1:0] RND    = XW'(longint'(1) << (FRAC-1));
  localparam logic signed [XW-1:0] K_HALF = XW'(PEAK);
  localparam logic signed [XW-1:0] K_QTR  = XW'(MID);
  localparam logic signed [XW-1:0] MID_S  = XW'(MID);
  localparam logic signed [XW-1:0] LO_S   = XW'(MARGIN);
  localparam logic signed [XW-1:0] HI_S   = XW'(PEAK - MARGIN);

  logic signed [XW-1:0] ds_x, ds_sat, ds_prev, dlt, half_t, corr_t;
  logic signed [XW-1:0] pr_v, sr_v, pf_v, sf_v;

  function automatic logic [CW-1:0] win(input logic signed [XW-1:0] v);
    if (v < LO_S)      return CW'(MARGIN);
    else if (v > HI_S) return CW'(PEAK - MARGIN);
    else               return v[CW-1:0];
  endfunction

  assign ds_x   = XW'(ds_req);
  assign ds_sat = (ds_x > LIM) ? LIM : ((ds_x < -LIM) ? -LIM : ds_x);
  assign dlt    = ds_sat - ds_prev;

  assign half_t = (ds_sat * K_HALF + RND) >>> FRAC;
  assign corr_t = (dlt * K_QTR + RND) >>> FRAC;

  assign pr_v = MID_S - half_t + corr_t;
  assign sr_v = MID_S + half_t - corr_t;
  assign pf_v = MID_S + half_t;
  assign sf_v = MID_S - half_t;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ds_prev      <= '0;
      pri_rise_cmp <= CW'(MID);
      sec_rise_cmp <= CW'(MID);
      pri_fall_cmp <= CW'(MID);
      sec_fall_cmp <= CW'(MID);
    end else if (cycle_start) begin
      ds_prev      <= ds_sat;
      pri_rise_cmp <= win(pr_v);
      sec_rise_cmp <= win(sr_v);
      pri_fall_cmp <= win(pf_v);
      sec_fall_cmp <= win(sf_v);
    end
  end
endmodule

// File: rtl/edge_calc_chk.sv
module edge_calc_chk #(
  parameter int PEAK   = 1250,
  parameter int MARGIN = 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cycle_start,
  input logic [$clog2(PEAK+1)-1:0] pri_rise_cmp,
  input logic [$clog2(PEAK+1)-1:0] sec_rise_cmp,
  input logic [$clog2(PEAK+1)-1:0] pri_fall_cmp,
  input logic [$clog2(PEAK+1)-1:0] sec_fall_cmp
);
  a_r5_window: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pri_rise_cmp) >= MARGIN && int'(pri_rise_cmp) <= PEAK - MARGIN &&
    int'(sec_rise_cmp) >= MARGIN && int'(sec_rise_cmp) <= PEAK - MARGIN &&
    int'(pri_fall_cmp) >= MARGIN && int'(pri_fall_cmp) <= PEAK - MARGIN &&
    int'(sec_fall_cmp) >= MARGIN && int'(sec_fall_cmp) <= PEAK - MARGIN);

  a_r9_rise_pair: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pri_rise_cmp) + int'(sec_rise_cmp) == PEAK);

  a_r9_fall_pair: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pri_fall_cmp) + int'(sec_fall_cmp) == PEAK);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_start |=> ($stable(pri_rise_cmp) && $stable(sec_rise_cmp) &&
                      $stable(pri_fall_cmp) && $stable(sec_fall_cmp)));
endmodule

bind phase_edge_calc edge_calc_chk #(.PEAK(PEAK), .MARGIN(MARGIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start),
  .pri_rise_cmp(pri_rise_cmp), .sec_rise_cmp(sec_rise_cmp),
  .pri_fall_cmp(pri_fall_cmp), .sec_fall_cmp(sec_fall_cmp)
);

// File: tb/tb_phase_edge_calc.sv
module tb_phase_edge_calc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cycle_start = 1'b0;
  logic signed [15:0] ds_req = '0;
  logic [10:0] a_pr, a_sr, a_pf, a_sf;
  logic [10:0] b_pr, b_sr, b_pf, b_sf;

  int checks = 0;
  int errors = 0;
  longint prev = 0;

  always #4 clk = ~clk;

  phase_edge_calc dut (
    .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .ds_req(ds_req),
    .pri_rise_cmp(a_pr), .sec_rise_cmp(a_sr), .pri_fall_cmp(a_pf), .sec_fall_cmp(a_sf));

  phase_edge_calc #(.MARGIN(400)) dut_clamp (
    .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .ds_req(ds_req),
    .pri_rise_cmp(b_pr), .sec_rise_cmp(b_sr), .pri_fall_cmp(b_pf), .sec_fall_cmp(b_sf));

  function automatic longint sat(longint v);
    if (v > 8192) return 8192;
    if (v < -8192) return -8192;
    return v;
  endfunction

  function automatic longint rnd15(longint x);
    return (x + 16384) >>> 15;
  endfunction

  function automatic longint lim(longint v, longint m);
    if (v < m) return m;
    if (v > 1250 - m) return 1250 - m;
    return v;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(logic signed [15:0] ds, string req);
    longint s, h, c;
    @(negedge clk);
    ds_req = ds;
    cycle_start = 1'b1;
    s = sat(longint'(ds));
    h = rnd15(s * 1250);
    c = rnd15((s - prev) * 625);
    @(negedge clk);
    cycle_start = 1'b0;
    ds_req = 16'(1234);
    chk({req, "/R3"}, "pri_rise", longint'(a_pr), lim(625 - h + c, 1));
    chk({req, "/R3"}, "sec_rise", longint'(a_sr), lim(625 + h - c, 1));
    chk({req, "/R2"}, "pri_fall", longint'(a_pf), lim(625 + h, 1));
    chk({req, "/R2"}, "sec_fall", longint'(a_sf), lim(625 - h, 1));
    chk({req, "/R5"}, "clamp pri_rise", longint'(b_pr), lim(625 - h + c, 400));
    chk({req, "/R5"}, "clamp sec_rise", longint'(b_sr), lim(625 + h - c, 400));
    chk({req, "/R5"}, "clamp pri_fall", longint'(b_pf), lim(625 + h, 400));
    chk({req, "/R5"}, "clamp sec_fall", longint'(b_sf), lim(625 - h, 400));
    prev = s;
  endtask

  task automatic hold(int n);
    logic [10:0] p0, p1, p2, p3;
    p0 = a_pr; p1 = a_sr; p2 = a_pf; p3 = a_sf;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ds_req = 16'($urandom);
    end
    chk("R6", "hold pri_rise", longint'(a_pr), longint'(p0));
    chk("R6", "hold sec_rise", longint'(a_sr), longint'(p1));
    chk("R6", "hold pri_fall", longint'(a_pf), longint'(p2));
    chk("R6", "hold sec_fall", longint'(a_sf), longint'(p3));
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R7", "reset pri_rise", longint'(a_pr), 625);
    chk("R7", "reset sec_rise", longint'(a_sr), 625);
    chk("R7", "reset pri_fall", longint'(a_pf), 625);
    chk("R7", "reset sec_fall", longint'(a_sf), 625);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7", "post-reset hold", longint'(a_pr), 625);

    step(16'sd4000, "R8");
    hold(7);
    step(16'sd8192, "R3");
    step(16'sd0, "R3");
    step(-16'sd8192, "R3");
    step(16'sd8192, "R3");
    step(-16'sd8192, "R3");
    step(16'sd20000, "R1");
    step(16'sd8192, "R4");
    step(-16'sd30000, "R1");
    step(-16'sd8192, "R4");
    step(16'sd1, "R3");
    step(-16'sd1, "R3");
    hold(5);

    for (int i = 0; i < 600; i++) begin
      logic signed [15:0] ds;
      if ($urandom_range(3) == 0) ds = 16'($urandom);
      else ds = 16'(int'($urandom_range(16384)) - 8192);
      step(ds, "R3");
      if ($urandom_range(4) == 0) hold(int'($urandom_range(6)) + 1);
    end

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R7", "re-reset pri_rise", longint'(a_pr), 625);
    chk("R7", "re-reset sec_fall", longint'(a_sf), 625);
    rst_n = 1'b1;
    prev = 0;
    step(-16'sd6000, "R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule